// File: doc/BRIEF.md
# Gated Intermediate-Frequency Counter

This block measures the frequency of an intermediate-frequency signal by counting its rising edges over a timed gate window. Software or a control sequencer pulses `startReq` after it loads new tuning data. The block then clears its result and waits a settling interval so the synthesizer can lock. After that it opens the gate for 1, 4, 16 or 64 ms, as chosen by `gateSel`. Once the gate closes, the result stays on `count` until the next start, and a serial readout path outside the block can read it.

All timing comes from `refTick`, a one-cycle pulse at 1 kHz or faster. `TICKS_PER_MS` says how many ticks make one millisecond. The settling wait is 4 ms for the two short gates and 8 ms for the two long gates. Because a start arrives at an arbitrary point within a tick period, the real wait lies up to one tick period below its nominal length. `busy` is high for the whole wait plus gate. `overflow` reports a count that went past the counter's range.

Top module: `if_gate_counter`

## Requirements
- R1: After reset, `busy`, `overflow` and `count` are all 0.
- R2: A start pulse sampled on a clock edge sets `count` to 0, sets `overflow` to 0 and sets `busy` to 1 from that edge on.
- R3: `busy` stays high for exactly (waitMs + gateMs) x `TICKS_PER_MS` tick periods, counted from the start edge. A tick sampled on the same edge as the start is not counted. waitMs is 4 when `gateSel[1]`=0 and 8 when `gateSel[1]`=1.
- R4: The gate length is set by `gateSel` (bit 0 = G0, bit 1 = G1): code 0 gives 1 ms, 1 gives 4 ms, 2 gives 16 ms and 3 gives 64 ms.
- R5: `count` equals the number of rising edges of `ifIn` seen while the gate is open. It stays 0 during the settling wait.
- R6: Once the gate has closed, `count` holds its value while `ifIn` keeps toggling, until the next start.
- R7: When the number of counted edges reaches 2^`CNT_W` (2^20 by default), `overflow` becomes 1 and `count` saturates at all ones. Fewer edges leave `overflow` at 0.
- R8: `overflow` stays at 1 after the measurement ends and is cleared only by the next start.
- R9: A start issued while `busy` is high abandons the current measurement and restarts the full sequence, beginning with the settling wait.
- R10: `gateSel` is captured at the start. Changing it while `busy` is high has no effect on the wait length, the gate length or the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refTick | input | 1 | One-cycle timing pulse, `TICKS_PER_MS` per millisecond |
| startReq | input | 1 | One-cycle start command |
| gateSel | input | 2 | Gate code: bit 0 = G0, bit 1 = G1 |
| ifIn | input | 1 | Intermediate-frequency signal (asynchronous) |
| busy | output | 1 | High during the wait and gate phases |
| overflow | output | 1 | Sticky flag: the count went past full scale |
| count | output | CNT_W | Measured edge count |

## Verification
The bench starts each measurement on the same edge as a tick and drives an input period that divides the tick period. The busy length and the edge count then have exact expected values. An off-by-one tick in the wait or gate counter, or a swapped wait/gate table, shows up as a wrong busy length or a wrong count. The bench reads the count one cycle before the gate opens, so a design that counts during the settling wait is caught. A second instance with a 6-bit counter is driven from the same stimulus to reach full scale. A design that wraps instead of saturating, drops the sticky flag early, or never clears it at the next start shows that at its ports. The bench also restarts a run in the middle of the gate and changes `gateSel` during a run. A design that continues the old window, keeps the old count, or reads the select input live then produces the wrong timing.

// File: rtl/ifgc_pkg.sv
`timescale 1ns/1ps
package ifgc_pkg;

  // Strobes from the sequencer to the counting datapath
  typedef struct packed {
    logic clearAll;   // zero count and overflow
    logic gateOpen;   // count qualified edges
  } ifgcStrobe_t;

  // Gate length in ms for code {G1,G0}: 1, 4, 16, 64
  function automatic int unsigned gateMs(input logic [1:0] code);
    return 32'd1 << (2 * code);
  endfunction

  // Settling wait in ms: long wait for the two long gates
  function automatic int unsigned waitMs(input logic [1:0] code,
                                         input int unsigned shortMs,
                                         input int unsigned longMs);
    return code[1] ? longMs : shortMs;
  endfunction

endpackage

// File: rtl/ifgc_edge.sv
`timescale 1ns/1ps
module ifgc_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic ifIn,
  output logic risePulse
);
  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= '0;
    else       pipe <= {pipe[PIPE_W-2:0], ifIn};
  end

  // rising edge: newest synchronised sample high, one older low
  assign risePulse = pipe[SYNC_STAGES-1] & ~pipe[SYNC_STAGES];
endmodule

// File: rtl/ifgc_ctrl.sv
`timescale 1ns/1ps
module ifgc_ctrl
  import ifgc_pkg::*;
#(
  parameter int TICKS_PER_MS  = 1,
  parameter int WAIT_SHORT_MS = 4,
  parameter int WAIT_LONG_MS  = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        refTick,
  input  logic        startReq,
  input  logic [1:0]  gateSel,
  output ifgcStrobe_t strobe,
  output logic        busy
);
  localparam int MAX_MS    = (WAIT_LONG_MS > 64) ? WAIT_LONG_MS : 64;
  localparam int MAX_TICKS = MAX_MS * TICKS_PER_MS;
  localparam int TW        = $clog2(MAX_TICKS + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_GATE} seqState_t;

  seqState_t       state;
  logic [TW-1:0]   tickCnt;
  logic [1:0]      codeQ;
  logic [TW-1:0]   waitLen;
  logic [TW-1:0]   gateLen;

  always_comb begin
    waitLen = TW'(waitMs(codeQ, WAIT_SHORT_MS, WAIT_LONG_MS) * TICKS_PER_MS);
    gateLen = TW'(gateMs(codeQ) * TICKS_PER_MS);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      codeQ   <= '0;
    end else if (startReq) begin
      state   <= ST_WAIT;
      tickCnt <= '0;
      codeQ   <= gateSel;
    end else begin
      unique case (state)
        ST_WAIT: if (refTick) begin
          if (tickCnt == waitLen - 1'b1) begin
            state   <= ST_GATE;
            tickCnt <= '0;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_GATE: if (refTick) begin
          if (tickCnt == gateLen - 1'b1) begin
            state   <= ST_IDLE;
            tickCnt <= '0;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    strobe.clearAll = startReq;
    strobe.gateOpen = (state == ST_GATE);
    busy            = (state != ST_IDLE);
  end
endmodule

// File: rtl/ifgc_datapath.sv
`timescale 1ns/1ps
module ifgc_datapath
  import ifgc_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  ifgcStrobe_t      strobe,
  input  logic             edgeSeen,
  output logic [CNT_W-1:0] cntQ,
  output logic             ovfQ
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
      ovfQ <= 1'b0;
    end else if (strobe.clearAll) begin
      cntQ <= '0;
      ovfQ <= 1'b0;
    end else if (strobe.gateOpen && edgeSeen) begin
      if (&cntQ) ovfQ <= 1'b1;         // saturate, flag past full scale
      else       cntQ <= cntQ + 1'b1;
    end
  end
endmodule

// File: rtl/if_gate_counter.sv
`timescale 1ns/1ps
module if_gate_counter
  import ifgc_pkg::*;
#(
  parameter int CNT_W         = 20,
  parameter int TICKS_PER_MS  = 1,
  parameter int SYNC_STAGES   = 2,
  parameter int WAIT_SHORT_MS = 4,
  parameter int WAIT_LONG_MS  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refTick,
  input  logic             startReq,
  input  logic [1:0]       gateSel,
  input  logic             ifIn,
  output logic             busy,
  output logic             overflow,
  output logic [CNT_W-1:0] count
);
  ifgcStrobe_t strobe;
  logic        risePulse;

  ifgc_edge #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
    .clk(clk), .rstN(rstN), .ifIn(ifIn), .risePulse(risePulse)
  );

  ifgc_ctrl #(
    .TICKS_PER_MS(TICKS_PER_MS),
    .WAIT_SHORT_MS(WAIT_SHORT_MS),
    .WAIT_LONG_MS(WAIT_LONG_MS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .refTick(refTick), .startReq(startReq),
    .gateSel(gateSel), .strobe(strobe), .busy(busy)
  );

  ifgc_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .edgeSeen(risePulse),
    .cntQ(count), .ovfQ(overflow)
  );
endmodule

// File: rtl/if_gate_counter_chk.sv
`timescale 1ns/1ps
module if_gate_counter_chk #(
  parameter int CNT_W = 20
) (
  input logic             clk,
  input logic             rstN,
  input logic             startReq,
  input logic             busy,
  input logic             overflow,
  input logic [CNT_W-1:0] count
);
  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    startReq |=> (busy && count == '0 && !overflow));

  a_r3_busy_from_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startReq));

  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !startReq) |=> $stable(count));

  a_r7_ovf_saturated: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> (&count));

  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !startReq) |=> overflow);
endmodule

bind if_gate_counter if_gate_counter_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .startReq(startReq), .busy(busy),
  .overflow(overflow), .count(count)
);

// File: tb/if_gate_counter_tb_top.sv
`timescale 1ns/1ps
module if_gate_counter_tb_top;
  localparam int TICK_T  = 32;   // clock cycles per tick (1 tick = 1 ms)
  localparam int SMALL_W = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [1:0] gateSel = 2'd0;
  logic ifEn = 1'b0;
  int   ifPeriod = 4;
  logic [31:0] cyc = '0;
  logic refTick, ifIn;

  logic busy, overflow, busyS, overflowS;
  logic [19:0] count;
  logic [SMALL_W-1:0] countS;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign refTick = ((cyc % TICK_T) == TICK_T - 1);
  assign ifIn    = ifEn && ((cyc % ifPeriod) < (ifPeriod / 2));

  if_gate_counter dut_i (
    .clk(clk), .rstN(rstN), .refTick(refTick), .startReq(startReq),
    .gateSel(gateSel), .ifIn(ifIn), .busy(busy), .overflow(overflow), .count(count)
  );

  if_gate_counter #(.CNT_W(SMALL_W)) small_i (
    .clk(clk), .rstN(rstN), .refTick(refTick), .startReq(startReq),
    .gateSel(gateSel), .ifIn(ifIn), .busy(busyS), .overflow(overflowS), .count(countS)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic startAligned(input logic [1:0] code);
    @(negedge clk);
    while (!refTick) @(negedge clk);
    gateSel  = code;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  // One measurement: start aligned with a tick, check every phase
  task automatic measure(input logic [1:0] code, input int period,
                         input bit swapSel, input string tag);
    int waitT, gateT, edges, n, held;
    waitT = (code[1] ? 8 : 4) * TICK_T;
    gateT = (1 << (2 * code)) * TICK_T;
    edges = gateT / period;
    ifPeriod = period;
    ifEn = 1'b1;
    startAligned(code);
    // R2: cleared and busy right after the start edge
    chk({tag, " R2 count cleared"}, int'(count), 0);
    chk({tag, " R2 overflow cleared"}, int'(overflow), 0);
    chk({tag, " R8 small overflow cleared by start"}, int'(overflowS), 0);
    chk({tag, " R2 busy"}, int'(busy), 1);
    if (swapSel) gateSel = ~code;   // R10: must be ignored
    n = 0;
    while (busy) begin
      n++;
      if (n == waitT) chk({tag, " R5 no count during wait"}, int'(count), 0);
      @(negedge clk);
    end
    chk({tag, " R3 R4 busy cycles"}, n, waitT + gateT);
    chk({tag, " R5 edge count"}, int'(count), edges);
    chk({tag, " R7 small count"}, int'(countS), (edges >= 64) ? 63 : edges);
    chk({tag, " R7 small overflow"}, int'(overflowS), (edges >= 64) ? 1 : 0);
    chk({tag, " R7 wide overflow"}, int'(overflow), 0);
    held = int'(count);
    repeat (3 * TICK_T) @(negedge clk);
    chk({tag, " R6 count held"}, int'(count), held);
    chk({tag, " R8 small overflow sticky"}, int'(overflowS), (edges >= 64) ? 1 : 0);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 overflow", int'(overflow), 0);
    chk("R1 count", int'(count), 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 busy after release", int'(busy), 0);
  endtask

  task automatic testGates();
    measure(2'd0, 4,  1'b0, "gate1ms");
    measure(2'd1, 2,  1'b0, "gate4ms ovf");
    measure(2'd1, 4,  1'b0, "gate4ms");
    measure(2'd2, 16, 1'b0, "gate16ms");
    measure(2'd3, 32, 1'b0, "gate64ms ovf");
  endtask

  task automatic testRestart();
    ifPeriod = 16;
    ifEn = 1'b1;
    startAligned(2'd2);
    repeat (8 * TICK_T + 100) @(negedge clk);
    chk("R9 counting before restart", int'(count != 0), 1);
    measure(2'd2, 16, 1'b0, "R9 restart");
  endtask

  task automatic testSelIgnored();
    measure(2'd0, 4, 1'b1, "R10 sel change");
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    testReset();
    testGates();
    testRestart();
    testSelIgnored();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule